// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a hardware watchdog. It pulls the system into reset when software stops servicing it. After system reset it stays dormant. Software arms it by writing a fixed two-byte key to its restart register. The same key, written again later, restarts the count. Once armed, software has no way to stop it. A 3-bit period field, written through a separate program register, selects how long the watchdog waits between services.

Counting runs on the single system clock through a tick enable, so no divided clock is produced. The tick comes at half the clock rate, or at the full clock rate when the clock-select input is clear and the double-speed mode input is set. The ticks drive a wide prescaler that feeds a 7-bit counter. When the count expires, the block drives a reset pulse of fixed length, shaped by a divide-by-six stage. The watchdog then falls back to its dormant, cleared state.

Top module: `keyed_wdt`

## Requirements
- R1: While `rstN` is low, and after it is released, `rstOut` is low, the watchdog is disabled, and the period field reads 0.
- R2: A write of 0x1E to the restart register (`wrRst`), followed by a write of 0xE1 as the next restart-register write, enables the watchdog and clears its count. Program-register writes and idle cycles may come between the two bytes.
- R3: Any other restart-register value or order has no effect. In particular, 0x1E followed by a byte other than 0xE1 drops the partial key, and 0xE1 alone does nothing.
- R4: With period field W = `wrData[2:0]` of the last program-register write (`wrPrg`), `rstOut` rises after exactly 2^PRE_W × 2^W ticks counted from the key's clearing edge.
- R5: When `selHalf`=1, or when `selHalf`=0 and `dblSpeed`=0, a tick occurs every second clock. The first tick comes on the second clock after a clear. When `selHalf`=0 and `dblSpeed`=1, a tick occurs on every clock.
- R6: A complete key written while the watchdog runs restarts the full period from that key.
- R7: Once enabled, no restart-register write of any value disables the watchdog or delays its expiry. Only the key restarts it.
- R8: On expiry, `rstOut` stays high for exactly 6 × RST_UNITS clocks.
- R9: When the pulse ends, the watchdog is disabled and cleared. Key writes made while `rstOut` is high are ignored. A later key starts a full new period.
- R10: Asserting `rstN` while the watchdog runs disables it, and no pulse follows after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| wrRst | input | 1 | Write strobe for the restart/enable register |
| wrPrg | input | 1 | Write strobe for the period-program register |
| wrData | input | 8 | Write data shared by both registers |
| selHalf | input | 1 | Tick source select: 1 = fixed half clock rate |
| dblSpeed | input | 1 | Double-speed mode; gives full-rate ticks when `selHalf` is 0 |
| rstOut | output | 1 | Stretched internal reset pulse |

## Verification
A stuck or misread key decoder shows at once: the watchdog either never fires or fires without a valid key. The first is seen one full period after the key, the second within one period of a bad sequence. A wrong prescaler, counter mask or tick phase moves the rising edge of `rstOut` by at least one clock, so every expiry is measured against an exact cycle count from the key edge. A pulse generator that miscounts, or fails to return to the dormant state, shows in the pulse width and in a stray second pulse within the following quiet window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WTO_W = 3;
  localparam logic [7:0] KEY_A = 8'h1E;
  localparam logic [7:0] KEY_B = 8'hE1;
  localparam int PULSE_DIV = 6;

  typedef struct packed {
    logic clr;  // zero prescaler, counter and tick phase
    logic run;  // watchdog enabled
  } wdtStb_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int RST_UNITS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrRst,
  input  logic             wrPrg,
  input  logic [7:0]       wrData,
  input  logic             ovfHit,
  output wdtStb_t          stb,
  output logic [WTO_W-1:0] wtoSel,
  output logic             rstOut
);
  localparam int UNIT_W = $clog2(RST_UNITS + 1);
  localparam int DIV_W = $clog2(PULSE_DIV);

  logic keyArmed;
  logic wdtEn;
  logic [DIV_W-1:0] divCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic keyHit;
  logic keyStart;

  // writes to the restart register are ignored while the pulse is driven
  assign keyStart = wrRst && !rstOut && (wrData == KEY_A);
  assign keyHit = wrRst && !rstOut && keyArmed && (wrData == KEY_B);

  assign stb.clr = keyHit || ovfHit;
  assign stb.run = wdtEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wtoSel <= '0;
    end else if (wrPrg) begin
      wtoSel <= wrData[WTO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyArmed <= 1'b0;
      wdtEn <= 1'b0;
    end else if (ovfHit) begin
      keyArmed <= 1'b0;
      wdtEn <= 1'b0;
    end else if (wrRst && !rstOut) begin
      keyArmed <= keyStart;
      if (keyHit) begin
        wdtEn <= 1'b1;
      end
    end
  end

  // pulse generator: divide-by-six stage times RST_UNITS
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstOut <= 1'b0;
      divCnt <= '0;
      unitCnt <= '0;
    end else if (ovfHit) begin
      rstOut <= 1'b1;
      divCnt <= '0;
      unitCnt <= '0;
    end else if (rstOut) begin
      if (divCnt == DIV_W'(PULSE_DIV - 1)) begin
        divCnt <= '0;
        if (unitCnt == UNIT_W'(RST_UNITS - 1)) begin
          rstOut <= 1'b0;
        end else begin
          unitCnt <= unitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PRE_W = 14,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStb_t          stb,
  input  logic             selHalf,
  input  logic             dblSpeed,
  input  logic [WTO_W-1:0] wtoSel,
  output logic             ovfHit
);
  logic phase;
  logic tickEn;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] perMask;

  assign tickEn = stb.run && ((!selHalf && dblSpeed) || phase);
  assign perMask = ~({CNT_W{1'b1}} << wtoSel);
  assign ovfHit = tickEn && (&preCnt) && ((perCnt & perMask) == perMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 1'b0;
      preCnt <= '0;
      perCnt <= '0;
    end else if (stb.clr) begin
      phase <= 1'b0;
      preCnt <= '0;
      perCnt <= '0;
    end else if (stb.run) begin
      phase <= ~phase;
      if (tickEn) begin
        preCnt <= preCnt + 1'b1;
        if (&preCnt) begin
          perCnt <= perCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int PRE_W = 14,
  parameter int CNT_W = 7,
  parameter int RST_UNITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrRst,
  input  logic       wrPrg,
  input  logic [7:0] wrData,
  input  logic       selHalf,
  input  logic       dblSpeed,
  output logic       rstOut
);
  wdtStb_t stb;
  logic ovfHit;
  logic [WTO_W-1:0] wtoSel;

  wdt_ctrl #(.RST_UNITS(RST_UNITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrRst(wrRst), .wrPrg(wrPrg), .wrData(wrData),
    .ovfHit(ovfHit), .stb(stb), .wtoSel(wtoSel), .rstOut(rstOut)
  );

  wdt_datapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selHalf(selHalf),
    .dblSpeed(dblSpeed), .wtoSel(wtoSel), .ovfHit(ovfHit)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrRst,
  input logic [7:0] wrData,
  input logic       rstOut,
  input wdtStb_t    stb,
  input logic       ovfHit
);
  // R2
  key_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrRst && wrData == KEY_B && !rstOut && !ovfHit &&
     $past(wrRst && wrData == KEY_A && !rstOut)) |=> stb.run);

  // R3
  enable_needs_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.run) |-> $past(wrRst && wrData == KEY_B));

  // R7
  no_soft_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.run) |-> $rose(rstOut));

  // R4
  expiry_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfHit |=> rstOut);

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |-> (!stb.run && !ovfHit));
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rstN(rstN), .wrRst(wrRst), .wrData(wrData),
  .rstOut(rstOut), .stb(stb), .ovfHit(ovfHit)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int PRE_W = 4;
  localparam int RST_UNITS = 4;
  localparam int PULSE = 6 * RST_UNITS;
  localparam int LIMIT = 10000;

  // {selHalf, dblSpeed, period field, expected cycles to expiry}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b1, 1'b0, 3'd0, 12'd32},
    {1'b0, 1'b0, 3'd0, 12'd32},
    {1'b0, 1'b1, 3'd0, 12'd16},
    {1'b1, 1'b1, 3'd0, 12'd32},
    {1'b0, 1'b1, 3'd3, 12'd128},
    {1'b1, 1'b0, 3'd2, 12'd128},
    {1'b0, 1'b1, 3'd7, 12'd2048},
    {1'b1, 1'b0, 3'd5, 12'd1024}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrRst = 1'b0;
  logic wrPrg = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic selHalf = 1'b1;
  logic dblSpeed = 1'b0;
  logic rstOut;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  keyed_wdt #(.PRE_W(PRE_W), .RST_UNITS(RST_UNITS)) u_keyed_wdt (
    .clk(clk), .rstN(rstN), .wrRst(wrRst), .wrPrg(wrPrg), .wrData(wrData),
    .selHalf(selHalf), .dblSpeed(dblSpeed), .rstOut(rstOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendRst(input logic [7:0] d);
    @(negedge clk); wrRst = 1'b1; wrData = d;
    @(negedge clk); wrRst = 1'b0;
  endtask

  task automatic sendPrg(input logic [7:0] d);
    @(negedge clk); wrPrg = 1'b1; wrData = d;
    @(negedge clk); wrPrg = 1'b0;
  endtask

  // counts clocks from the key's clearing edge until rstOut rises
  task automatic waitExpiry(inout int lat);
    while (!rstOut && lat < LIMIT) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic keyAndMeasure(output int lat);
    sendRst(8'h1E);
    sendRst(8'hE1);
    lat = 0;
    waitExpiry(lat);
  endtask

  task automatic pulseLen(output int len);
    len = 0;
    while (rstOut && len < LIMIT) begin
      len++; @(negedge clk);
    end
  endtask

  task automatic expectQuiet(input string req, input int cycles);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (rstOut) seen = 1;
    end
    check(req, seen, 0);
  endtask

  initial begin
    int lat;
    int len;
    repeat (3) @(negedge clk);
    check("R1 rstOut low in reset", int'(rstOut), 0);
    rstN = 1'b1;
    selHalf = 1'b0; dblSpeed = 1'b1;
    expectQuiet("R1 dormant after reset", 200);

    // table walk: R4 and R5 periods, R8 pulse width
    for (int i = 0; i < 8; i++) begin
      selHalf = VEC[i][16];
      dblSpeed = VEC[i][15];
      sendPrg({5'b0, VEC[i][14:12]});
      keyAndMeasure(lat);
      check($sformatf("R4/R5 expiry vector %0d", i), lat, int'(VEC[i][11:0]));
      pulseLen(len);
      check($sformatf("R8 pulse width vector %0d", i), len, PULSE);
    end

    // R3: wrong order, interrupted key, lone second byte
    selHalf = 1'b1; dblSpeed = 1'b0;
    sendPrg(8'h00);
    sendRst(8'hE1); sendRst(8'h1E); sendRst(8'h55); sendRst(8'hE1);
    expectQuiet("R3 bad key sequences", 200);

    // R2: program write between key bytes still completes the key
    sendRst(8'h1E);
    sendPrg(8'h00);
    sendRst(8'hE1);
    lat = 0; waitExpiry(lat);
    check("R2 key with interleaved program write", lat, 32);
    pulseLen(len);

    // R6: second key restarts the period
    sendRst(8'h1E); sendRst(8'hE1);
    repeat (20) @(negedge clk);
    keyAndMeasure(lat);
    check("R6 restart from second key", lat, 32);
    pulseLen(len);

    // R7: stray writes neither stop nor delay expiry
    sendRst(8'h1E); sendRst(8'hE1);
    lat = 0;
    sendRst(8'h00); sendRst(8'h55); sendRst(8'h1E); sendRst(8'h00);
    lat = 8;
    waitExpiry(lat);
    check("R7 no software disable", lat, 32);

    // R9: key during pulse ignored, dormant afterwards
    sendRst(8'h1E); sendRst(8'hE1);
    pulseLen(len);
    check("R9 pulse width with key inside", len + 4, PULSE);
    expectQuiet("R9 dormant after pulse", 200);
    keyAndMeasure(lat);
    check("R9 fresh period after pulse", lat, 32);
    pulseLen(len);

    // R10: system reset disables a running watchdog
    sendPrg(8'h02);
    sendRst(8'h1E); sendRst(8'hE1);
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 rstOut low in reset", int'(rstOut), 0);
    rstN = 1'b1;
    expectQuiet("R10 disabled after reset", 400);
    keyAndMeasure(lat);
    check("R1 period field cleared by reset", lat, 32);
    pulseLen(len);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end
endmodule